// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block keeps the configuration of a larger datapath. A host writes bytes over an 8-bit parallel address/data port. Each write lands in a shadow copy, and the live copy that drives downstream logic does not change. The live copy changes only when a transfer moves every shadow byte across in one system clock cycle, so downstream logic never sees a half-applied configuration. The host reads back the shadow copy, so pending values can be checked before they are applied.

A transfer can come from two sources. One is an internal down-counter that fires every programmed number of cycles. The other is a rising edge on an external update pin, which is first synchronised. A mode bit held in the live copy selects the source. The clock-enable input models a stopped system clock: host accesses keep working, but no transfer, timer step or synchroniser step happens. The raw reset input counts only once it has stayed high for a minimum run of enabled cycles. At that point both copies load their defaults.

Top module: `cfgbank_top`

## Requirements
- R1: A host write (host_wr high, host_addr below 12) changes the shadow byte at that address on the next clock edge and leaves cfg_out unchanged until a transfer. host_rdata always shows the shadow byte at host_addr.
- R2: Addresses 0 to 11 are the twelve banks. Writes to addresses 12 to 15 change no bank, and reads of those addresses return 0.
- R3: With the mode bit (bit 0 of bank 4) clear, a rising edge on ext_update copies all twelve shadow bytes to cfg_out on the third clock edge after the input goes high. Holding the input high gives exactly one transfer.
- R4: With the live mode bit set, a transfer happens every P+1 cycles, where P is the 32-bit period formed from banks 0 to 3 (bank 0 least significant), and ext_update has no effect. The timer reloads from the period that is being copied in the same cycle.
- R5: While sclk_en is low, host writes and reads still work, but no transfer happens, and the timer and the ext_update synchroniser hold their state.
- R6: When rst_in has been high for 10 consecutive enabled cycles, shadow and live copies both load their defaults on that 10th edge. The defaults are: bank 0 = 0x0F, banks 1 to 4 = 0x00 (external mode, period 15), and bank k = 16*k for k = 5 to 11. Reset holds while rst_in stays high.
- R7: A run of rst_in shorter than 10 enabled cycles changes nothing. The count restarts from zero whenever rst_in goes low.
- R8: xfer_done is high for the one cycle after each transfer edge and low otherwise. cfg_out bank k sits at bits 8k+7 to 8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sclk_en | input | 1 | System clock present; gates the update and reset logic |
| rst_in | input | 1 | Raw active-high reset, qualified by pulse length |
| host_addr | input | 4 | Bank address for reads and writes |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one byte per cycle |
| host_rdata | output | 8 | Shadow byte at host_addr |
| ext_update | input | 1 | Asynchronous external transfer request |
| cfg_out | output | 96 | Live configuration, all banks |
| xfer_done | output | 1 | High the cycle after a transfer |

## Verification
Transfers are driven three ways: by an external edge, by the timer with periods 4 and 0, and by the timer with a long period that leaves a window to show an external edge being ignored. Each case tells the two sources apart and checks that the reload uses the incoming period. The external path is checked at the exact cycle, one cycle before and at the copy edge, and with the pin held high to tell edge triggering from level triggering. Reset is tried as a 9-cycle pulse, as a split 5+5 pulse and as a full 10-cycle pulse, which separates a counter that restarts from one that only accumulates. Writes to unused addresses and accesses with the clock stopped are checked through readback and cfg_out.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int BANK_W    = 8;
    localparam int PERIOD_W  = 32;
    localparam int CTRL_BANK = 4;
    localparam int AUTO_BIT  = 0;
    localparam int LOW_W     = BANK_W * (CTRL_BANK + 1);

    typedef struct packed {
        logic                auto_mode;
        logic [PERIOD_W-1:0] period;
    } upd_ctrl_t;

    function automatic logic [BANK_W-1:0] bank_default(input int idx);
        if (idx == 0)
            return 8'h0F;
        else if (idx <= CTRL_BANK)
            return 8'h00;
        else
            return 8'(idx * 16);
    endfunction

    function automatic upd_ctrl_t decode_ctrl(input logic [LOW_W-1:0] low);
        upd_ctrl_t c;
        c.period    = low[PERIOD_W-1:0];
        c.auto_mode = low[BANK_W*CTRL_BANK + AUTO_BIT];
        return c;
    endfunction

    function automatic logic [PERIOD_W-1:0] period_of(input logic [LOW_W-1:0] low);
        return low[PERIOD_W-1:0];
    endfunction

endpackage

// File: rtl/cfgbank_rst_qual.sv
module cfgbank_rst_qual #(
    parameter int MIN_CYC = 10
) (
    input  logic clk,
    input  logic sclk_en,
    input  logic rst_in,
    output logic rst_act,
    output logic armed
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_in)
            run_q <= '0;
        else if (sclk_en && run_q != LAST)
            run_q <= run_q + 1'b1;
    end

    assign rst_act = rst_in && sclk_en && (run_q == LAST);

    always_ff @(posedge clk) begin
        if (rst_act)
            armed <= 1'b1;
    end

    // R7
    qual_needs_history_chk: assert property (@(posedge clk) disable iff (!armed)
        rst_act |-> $past(rst_in));

    // R7
    fresh_pulse_chk: assert property (@(posedge clk) disable iff (!armed)
        (rst_in && !$past(rst_in)) |-> !rst_act);

endmodule

// File: rtl/cfgbank_edge_sync.sv
module cfgbank_edge_sync (
    input  logic clk,
    input  logic en,
    input  logic clr,
    input  logic async_in,
    output logic rise
);
    logic [2:0] sh_q;

    always_ff @(posedge clk) begin
        if (clr)
            sh_q <= '0;
        else if (en)
            sh_q <= {sh_q[1:0], async_in};
    end

    assign rise = en && sh_q[1] && !sh_q[2];

endmodule

// File: rtl/cfgbank_upd_timer.sv
module cfgbank_upd_timer
    import cfgbank_pkg::*;
(
    input  logic                clk,
    input  logic                en,
    input  logic                clr,
    input  logic                auto_mode,
    input  logic [PERIOD_W-1:0] reload_val,
    output logic                tick
);
    logic [PERIOD_W-1:0] cnt_q;

    assign tick = en && auto_mode && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (clr)
            cnt_q <= '0;
        else if (en) begin
            if (!auto_mode || cnt_q == '0)
                cnt_q <= reload_val;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
    import cfgbank_pkg::*;
#(
    parameter int NUM_BANKS = 12,
    parameter int MIN_RST   = 10
) (
    input  logic                          clk,
    input  logic                          sclk_en,
    input  logic                          rst_in,
    input  logic [$clog2(NUM_BANKS)-1:0]  host_addr,
    input  logic [BANK_W-1:0]             host_wdata,
    input  logic                          host_wr,
    output logic [BANK_W-1:0]             host_rdata,
    input  logic                          ext_update,
    output logic [NUM_BANKS*BANK_W-1:0]   cfg_out,
    output logic                          xfer_done
);
    localparam int AW = $clog2(NUM_BANKS);

    typedef logic [NUM_BANKS-1:0][BANK_W-1:0] bank_arr_t;

    function automatic bank_arr_t defaults_all();
        bank_arr_t r;
        for (int i = 0; i < NUM_BANKS; i++)
            r[i] = bank_default(i);
        return r;
    endfunction

    localparam bank_arr_t DEFAULTS = defaults_all();

    bank_arr_t           shadow_q, active_q;
    upd_ctrl_t           act_ctrl;
    logic [PERIOD_W-1:0] reload_val;
    logic                rst_act, armed, tick, ext_rise, xfer;

    cfgbank_rst_qual #(.MIN_CYC(MIN_RST)) u_qual (
        .clk     (clk),
        .sclk_en (sclk_en),
        .rst_in  (rst_in),
        .rst_act (rst_act),
        .armed   (armed)
    );

    cfgbank_edge_sync u_sync (
        .clk      (clk),
        .en       (sclk_en),
        .clr      (rst_act),
        .async_in (ext_update),
        .rise     (ext_rise)
    );

    assign act_ctrl   = decode_ctrl(active_q[CTRL_BANK:0]);
    assign xfer       = sclk_en && (act_ctrl.auto_mode ? tick : ext_rise);
    assign reload_val = xfer ? period_of(shadow_q[CTRL_BANK:0]) : act_ctrl.period;

    cfgbank_upd_timer u_timer (
        .clk        (clk),
        .en         (sclk_en),
        .clr        (rst_act),
        .auto_mode  (act_ctrl.auto_mode),
        .reload_val (reload_val),
        .tick       (tick)
    );

    // Shadow copy: host side
    always_ff @(posedge clk) begin
        if (rst_act)
            shadow_q <= DEFAULTS;
        else begin
            for (int i = 0; i < NUM_BANKS; i++)
                if (host_wr && host_addr == AW'(i))
                    shadow_q[i] <= host_wdata;
        end
    end

    always_comb begin
        host_rdata = '0;
        for (int i = 0; i < NUM_BANKS; i++)
            if (host_addr == AW'(i))
                host_rdata = shadow_q[i];
    end

    // Live copy: whole-array transfer
    always_ff @(posedge clk) begin
        if (rst_act) begin
            active_q  <= DEFAULTS;
            xfer_done <= 1'b0;
        end else begin
            if (xfer)
                active_q <= shadow_q;
            xfer_done <= xfer;
        end
    end

    assign cfg_out = active_q;

    // R1
    live_hold_chk: assert property (@(posedge clk) disable iff (!armed || rst_act)
        !xfer |=> $stable(active_q));

    // R2
    unused_addr_chk: assert property (@(posedge clk) disable iff (!armed || rst_act)
        (host_wr && {1'b0, host_addr} >= (AW+1)'(NUM_BANKS)) |=> $stable(shadow_q));

    // R5
    no_clk_xfer_chk: assert property (@(posedge clk) disable iff (!armed || rst_act)
        !sclk_en |=> !xfer_done);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!armed || rst_act)
        xfer |=> (xfer_done && active_q == $past(shadow_q)));

    // R6
    defaults_chk: assert property (@(posedge clk) disable iff (!armed)
        rst_act |=> (active_q == DEFAULTS && shadow_q == DEFAULTS && !xfer_done));

endmodule

// File: tb/tb_cfgbank_top.sv
module tb_cfgbank_top;
    logic        clk = 1'b0;
    logic        sclk_en = 1'b1;
    logic        rst_in = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_rdata;
    logic        ext_update = 1'b0;
    logic [95:0] cfg_out;
    logic        xfer_done;

    always #5 clk = ~clk;

    cfgbank_top dut (
        .clk(clk), .sclk_en(sclk_en), .rst_in(rst_in), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_wr(host_wr), .host_rdata(host_rdata),
        .ext_update(ext_update), .cfg_out(cfg_out), .xfer_done(xfer_done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] m_shadow [12];
    logic [7:0] m_active [12];

    typedef struct {
        int          kind;
        logic [95:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    function automatic logic [95:0] pack_active();
        logic [95:0] v;
        for (int i = 0; i < 12; i++) v[8*i +: 8] = m_active[i];
        return v;
    endfunction

    function automatic logic [7:0] def_byte(input int k);
        if (k == 0) return 8'h0F;
        if (k < 5) return 8'h00;
        return 8'(16 * k);
    endfunction

    // Monitor: compares queued expectations away from the active edge
    always begin
        @(negedge clk);
        while (sb_q.size() > 0) begin
            item_t it;
            logic [95:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0: act = cfg_out;
                1: act = {88'd0, host_rdata};
                default: act = {95'd0, xfer_done};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic push(input int kind, input logic [95:0] exp, input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic exp_cfg(input string req);
        push(0, pack_active(), req);
    endtask

    task automatic exp_rd(input int a, input string req);
        host_addr = 4'(a);
        push(1, {88'd0, (a < 12) ? m_shadow[a] : 8'h00}, req);
        step();
    endtask

    task automatic direct(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [7:0] d);
        host_addr = 4'(a); host_wdata = d; host_wr = 1'b1;
        step();
        host_wr = 1'b0;
        if (a < 12) m_shadow[a] = d;
    endtask

    task automatic load_defaults();
        for (int k = 0; k < 12; k++) begin
            m_shadow[k] = def_byte(k);
            m_active[k] = def_byte(k);
        end
    endtask

    task automatic do_reset(input int n);
        rst_in = 1'b1;
        for (int i = 0; i < n; i++) step();
        rst_in = 1'b0;
        if (n >= 10) load_defaults();
    endtask

    // External transfer with cycle-exact checks (R3, R8)
    task automatic ext_pulse();
        ext_update = 1'b1;
        step();
        step();
        exp_cfg("R3_before_third_edge");
        step();
        for (int k = 0; k < 12; k++) m_active[k] = m_shadow[k];
        exp_cfg("R3_copy");
        push(2, 96'd1, "R8_done_high");
        step();
        push(2, 96'd0, "R3_R8_single_pulse");
        ext_update = 1'b0;
        step();
    endtask

    task automatic measure_gap(output int g);
        g = 0;
        do begin
            step();
            g++;
        end while (!xfer_done && g < 1000);
    endtask

    initial begin
        int gap;
        for (int k = 0; k < 12; k++) begin m_shadow[k] = 0; m_active[k] = 0; end
        step();

        // R6: qualified reset loads defaults
        do_reset(12);
        step();
        exp_cfg("R6_reset_cfg");
        push(2, 96'd0, "R8_idle_after_reset");
        exp_rd(0, "R6_rd_bank0");
        exp_rd(11, "R6_rd_bank11");

        // R1: write stays in shadow
        host_write(6, 8'h22);
        exp_cfg("R1_no_effect");
        exp_rd(6, "R1_readback_pending");
        ext_pulse();
        exp_rd(6, "R1_readback_after");

        // R7: short reset pulses ignored
        host_write(5, 8'h11);
        ext_pulse();
        do_reset(9);
        step();
        exp_cfg("R7_nine_cycles");
        exp_rd(5, "R7_rd_nine");
        rst_in = 1'b1;
        for (int i = 0; i < 5; i++) step();
        rst_in = 1'b0;
        step();
        do_reset(5);
        step();
        exp_cfg("R7_split_pulse");
        exp_rd(5, "R7_rd_split");

        // R2: unused addresses
        for (int a = 12; a < 16; a++) host_write(a, 8'hFF);
        exp_rd(12, "R2_rd_unused12");
        exp_rd(15, "R2_rd_unused15");
        for (int a = 0; a < 12; a++) exp_rd(a, "R2_banks_intact");
        ext_pulse();

        // R5: stopped system clock
        sclk_en = 1'b0;
        host_write(9, 8'h99);
        exp_rd(9, "R5_write_no_clock");
        ext_update = 1'b1;
        for (int i = 0; i < 5; i++) step();
        ext_update = 1'b0;
        step();
        exp_cfg("R5_no_transfer");
        push(2, 96'd0, "R5_no_done");
        step();
        sclk_en = 1'b1;
        for (int i = 0; i < 4; i++) step();
        exp_cfg("R5_no_late_transfer");
        ext_pulse();

        // R4: internal timer, period 4
        host_write(0, 8'd4);
        host_write(1, 8'd0);
        host_write(2, 8'd0);
        host_write(3, 8'd0);
        host_write(4, 8'h01);
        ext_pulse();
        measure_gap(gap);
        measure_gap(gap);
        direct(gap == 5, "R4_gap_p4_a", gap, 5);
        measure_gap(gap);
        direct(gap == 5, "R4_gap_p4_b", gap, 5);

        // R4: period 0 -> every cycle
        host_write(0, 8'd0);
        for (int i = 0; i < 8; i++) step();
        measure_gap(gap);
        direct(gap == 1, "R4_gap_p0", gap, 1);

        // R4: long period, external edge ignored
        host_write(0, 8'd200);
        step();
        step();
        for (int k = 0; k < 12; k++) m_active[k] = m_shadow[k];
        exp_cfg("R4_auto_copied");
        step();
        host_write(7, 8'h77);
        ext_update = 1'b1;
        for (int i = 0; i < 5; i++) step();
        ext_update = 1'b0;
        step();
        exp_cfg("R4_ext_ignored");
        exp_rd(7, "R4_rd_pending");

        // back to external mode at next timer transfer
        host_write(4, 8'h00);
        measure_gap(gap);
        direct(gap < 300, "R4_timer_fired", gap, 201);
        for (int k = 0; k < 12; k++) m_active[k] = m_shadow[k];
        step();
        exp_cfg("R4_mode_switch_copy");
        host_write(8, 8'h5A);
        ext_pulse();

        // R6: full reset after activity
        do_reset(10);
        step();
        exp_cfg("R6_reset_again");
        exp_rd(6, "R6_rd_shadow_default");
        step();

        step();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule